// File: doc/BRIEF.md
# ADC Conversion Clock Source Selector and Divider

This block produces the working clock of an analog-to-digital converter as a single-cycle clock enable in the bus clock domain. A 2-bit field chooses one of four sources, and a second 2-bit field divides the chosen source by 1, 2, 4 or 8. The four sources are the bus clock, the bus clock halved, an alternate clock and an internal oscillator. The alternate clock and the oscillator enter as tick strobes, one per source edge, that are synchronous to the bus clock.

The internal oscillator is requested only while a conversion is running on it, unless a force-on bit keeps it running permanently. After each request that starts it from off, the block counts a programmable number of oscillator ticks as start-up time. The ready flag stays low and no enable is issued on that source until the count completes. Forcing the oscillator on removes that latency from the start of each conversion. A new source or divide setting is taken only while no conversion is active. When it is taken, the divider count and the halving phase both restart from zero.

Top module: `adc_clk_gen`

## Requirements
- R1: After reset the bus clock is selected with divide-by-1, `osc_req` is 0, `clk_ready` is 1 and `adck_en` is high on every cycle.
- R2: `src_sel` encodes 00 = bus clock (a tick every cycle), 01 = bus clock halved (a tick on every second cycle, the first one on the second cycle after the setting is taken), 10 = `alt_tick`, 11 = `osc_tick`, which counts only once the oscillator is ready.
- R3: `div_sel` encodes 00/01/10/11 as divide-by 1/2/4/8. `adck_en` is a single-cycle pulse on every Nth source tick, counted from the cycle the setting was taken.
- R4: `src_sel` and `div_sel` are loaded on the clock edge that ends a cycle with no conversion active. A change made while a conversion is active has no effect until the conversion has stopped.
- R5: A conversion is active from the cycle after a `conv_start` strobe until the cycle after a `conv_stop` strobe. A stop in the same cycle as a start wins. `osc_req` is high exactly when `force_on` is 1 or when source 11 is selected and a conversion is active.
- R6: With source 11 selected, `clk_ready` and `adck_en` stay low until `startup_len` oscillator ticks have been counted since `osc_req` rose.
- R7: A `conv_stop` during start-up drops `osc_req` on the next cycle when `force_on` is 0. The next start repeats the full start-up delay.
- R8: With `force_on` at 1, the oscillator runs without any conversion and stays on through a stop, so a conversion that starts after start-up gets `clk_ready` and enables immediately.
- R9: With source 00, 01 or 10 selected, `clk_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alt_tick | input | 1 | One-cycle strobe per alternate clock edge |
| osc_tick | input | 1 | One-cycle strobe per internal oscillator edge |
| src_sel | input | 2 | Source select |
| div_sel | input | 2 | Divide select |
| force_on | input | 1 | Keep the internal oscillator running |
| conv_start | input | 1 | Conversion start strobe |
| conv_stop | input | 1 | Conversion stop strobe |
| startup_len | input | SU_W | Oscillator start-up length in ticks |
| adck_en | output | 1 | Divided conversion clock enable |
| osc_req | output | 1 | Oscillator enable request |
| clk_ready | output | 1 | Selected source is usable |

## Verification
The bench sweeps every non-oscillator source against every divide setting and compares each cycle's enable with a tick count kept by the bench. A divider that is not cleared at the switch, or a halving phase that keeps running across it, shows up as a shifted first pulse. For the oscillator source it checks cycle by cycle that the ready flag and the enables stay silent for exactly the start-up count. A design that kept a stale count would go ready too early after a stop in mid start-up. Other cases checked are a setting changed during a conversion, a start and a stop in the same cycle, and force-on keeping the oscillator alive through a stop. A design that got these wrong would switch sources mid-conversion, start a conversion it should have cancelled, or drop the oscillator.

// File: rtl/adc_clk_gen.sv
module adc_clk_gen #(
  parameter int SU_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alt_tick,
  input  logic            osc_tick,
  input  logic [1:0]      src_sel,
  input  logic [1:0]      div_sel,
  input  logic            force_on,
  input  logic            conv_start,
  input  logic            conv_stop,
  input  logic [SU_W-1:0] startup_len,
  output logic            adck_en,
  output logic            osc_req,
  output logic            clk_ready
);
  localparam logic [1:0] SRC_BUS  = 2'b00;
  localparam logic [1:0] SRC_HALF = 2'b01;
  localparam logic [1:0] SRC_ALT  = 2'b10;
  localparam logic [1:0] SRC_OSC  = 2'b11;

  logic            active;
  logic [1:0]      src_q, div_q;
  logic            half_ph;
  logic [2:0]      div_cnt, div_lim;
  logic [SU_W-1:0] su_cnt;
  logic            src_tick;

  wire osc_ok   = su_cnt >= startup_len;
  wire cfg_load = !active && (src_sel != src_q || div_sel != div_q);

  assign osc_req   = force_on || (src_q == SRC_OSC && active);
  assign clk_ready = (src_q != SRC_OSC) || (osc_req && osc_ok);

  always_comb begin
    case (src_q)
      SRC_BUS:  src_tick = 1'b1;
      SRC_HALF: src_tick = half_ph;
      SRC_ALT:  src_tick = alt_tick;
      default:  src_tick = osc_tick && clk_ready;
    endcase
  end

  always_comb begin
    case (div_q)
      2'd0:    div_lim = 3'd0;
      2'd1:    div_lim = 3'd1;
      2'd2:    div_lim = 3'd3;
      default: div_lim = 3'd7;
    endcase
  end

  assign adck_en = src_tick && (div_cnt == div_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= 1'b0;
    else if (conv_stop) active <= 1'b0;
    else if (conv_start) active <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= SRC_BUS;
      div_q   <= 2'd0;
      half_ph <= 1'b0;
      div_cnt <= 3'd0;
    end else if (cfg_load) begin
      src_q   <= src_sel;
      div_q   <= div_sel;
      half_ph <= 1'b0;
      div_cnt <= 3'd0;
    end else begin
      half_ph <= !half_ph;
      if (src_tick) div_cnt <= (div_cnt == div_lim) ? 3'd0 : div_cnt + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) su_cnt <= '0;
    else if (!osc_req) su_cnt <= '0;
    else if (osc_tick && !osc_ok) su_cnt <= su_cnt + 1'b1;
  end
endmodule

// File: rtl/adc_clk_gen_chk.sv
module adc_clk_gen_chk #(
  parameter int SU_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            force_on,
  input logic            conv_stop,
  input logic [SU_W-1:0] startup_len,
  input logic            adck_en,
  input logic            osc_req,
  input logic            clk_ready,
  input logic            active,
  input logic [1:0]      src_q,
  input logic [1:0]      div_q
);
  a_r5_stop_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
    conv_stop |=> (!osc_req || force_on));
  a_r6_no_en_unready: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_ready |-> !adck_en);
  a_r6_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == 2'b11 && clk_ready) |-> osc_req);
  a_r7_restart_delay: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(osc_req) && src_q == 2'b11 && startup_len != '0) |-> !clk_ready);
  a_r4_cfg_held_active: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> ($stable(src_q) && $stable(div_q)));
  a_r3_div1_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == 2'b00 && div_q == 2'b00) |-> adck_en);
  a_r9_ready_other: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q != 2'b11) |-> clk_ready);
endmodule

bind adc_clk_gen adc_clk_gen_chk #(.SU_W(SU_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .force_on(force_on), .conv_stop(conv_stop),
  .startup_len(startup_len), .adck_en(adck_en), .osc_req(osc_req),
  .clk_ready(clk_ready), .active(active), .src_q(src_q), .div_q(div_q)
);

// File: tb/adc_clk_gen_tb.sv
`timescale 1ns/1ps
module adc_clk_gen_tb_top;
  localparam int SU_W = 8;
  localparam int SU   = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alt_tick = 1'b0, osc_tick = 1'b0, force_on = 1'b0;
  logic conv_start = 1'b0, conv_stop = 1'b0;
  logic [1:0] src_sel = 2'b00, div_sel = 2'b00;
  logic [SU_W-1:0] startup_len = SU_W'(SU);
  logic adck_en, osc_req, clk_ready;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  adc_clk_gen #(.SU_W(SU_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .alt_tick(alt_tick), .osc_tick(osc_tick),
    .src_sel(src_sel), .div_sel(div_sel), .force_on(force_on),
    .conv_start(conv_start), .conv_stop(conv_stop), .startup_len(startup_len),
    .adck_en(adck_en), .osc_req(osc_req), .clk_ready(clk_ready)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic look3(input string req, input int e_en, input int e_req, input int e_rdy);
    @(negedge clk);
    chk(req, "adck_en", int'(adck_en), e_en);
    chk(req, "osc_req", int'(osc_req), e_req);
    chk(req, "clk_ready", int'(clk_ready), e_rdy);
  endtask

  task automatic sweep(input int s, input int d);
    int t = 0;
    int n = 1 << d;
    src_sel = 2'(s); div_sel = 2'(d);
    step();
    for (int k = 0; k < 32; k++) begin
      bit tk;
      alt_tick = (s == 2) && (k % 3 == 2);
      @(negedge clk);
      tk = (s == 0) ? 1'b1 : (s == 1) ? bit'(k % 2 == 1) : alt_tick;
      if (tk) t++;
      chk(s == 0 && d == 0 ? "R2 R3" : "R3", "adck_en", int'(adck_en), int'(tk && (t % n == 0)));
      chk("R9", "clk_ready", int'(clk_ready), 1);
      step();
    end
    alt_tick = 1'b0;
  endtask

  task automatic pulse_start();
    conv_start = 1'b1; step(); conv_start = 1'b0;
  endtask

  task automatic pulse_stop();
    conv_stop = 1'b1; step(); conv_stop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      look3("R1", 1, 0, 1);
      step();
    end

    for (int s = 0; s < 3; s++)
      for (int d = 0; d < 4; d++)
        sweep(s, d);

    // oscillator source, on demand
    osc_tick = 1'b1;
    src_sel = 2'b11; div_sel = 2'b00;
    step();
    for (int k = 0; k < 3; k++) begin
      look3("R6", 0, 0, 0);
      step();
    end
    pulse_start();
    for (int k = 0; k < 8; k++) begin
      look3("R6", int'(k >= SU), 1, int'(k >= SU));
      step();
    end
    // R4: change while active is ignored
    src_sel = 2'b00; div_sel = 2'b11;
    for (int k = 0; k < 4; k++) begin
      look3("R4", 1, 1, 1);
      step();
    end
    pulse_stop();
    look3("R5", 0, 0, 0);
    step();
    for (int k = 0; k < 16; k++) begin
      look3("R4", int'(k % 8 == 7), 0, 1);
      step();
    end

    // R7: stop during start-up, then full delay again
    src_sel = 2'b11; div_sel = 2'b00;
    step();
    pulse_start();
    look3("R7", 0, 1, 0);
    step();
    look3("R7", 0, 1, 0);
    pulse_stop();
    look3("R7", 0, 0, 0);
    step();
    pulse_start();
    for (int k = 0; k < 7; k++) begin
      look3("R7", int'(k >= SU), 1, int'(k >= SU));
      step();
    end
    pulse_stop();
    look3("R7", 0, 0, 0);
    step();

    // R5: start and stop in the same cycle, stop wins
    conv_start = 1'b1; conv_stop = 1'b1;
    step();
    conv_start = 1'b0; conv_stop = 1'b0;
    for (int k = 0; k < 3; k++) begin
      look3("R5", 0, 0, 0);
      step();
    end

    // R8: forced oscillator
    force_on = 1'b1;
    for (int k = 0; k < 8; k++) begin
      look3("R8", int'(k >= SU), 1, int'(k >= SU));
      step();
    end
    pulse_start();
    look3("R8", 1, 1, 1);
    step();
    pulse_stop();
    look3("R8", 1, 1, 1);
    step();
    force_on = 1'b0;
    look3("R5", 0, 0, 0);
    step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule